// File: doc/BRIEF.md
# Shadow Scan Chain for CPU Debug

This block is the device-side end of a serial debug link into a small CPU. An external host drives a serial clock and a data-in line and reads a data-out line. Inside the block, eight byte-wide shadow registers form one 64-bit shift path. One byte holds control flags. The other seven mirror the CPU's four general registers, its program counter and its 16-bit instruction register.

Each rising serial-clock edge normally shifts the path by one bit. A falling edge on the CPU clock arms a capture. The next rising serial-clock edge then copies the live CPU register values into the shadow bytes instead of shifting. After that, the host scans the snapshot out and scans new contents in at the same time.

The control byte drives two outputs to the CPU decoder. One tells the decoder to decode the shadow instruction word. The other gates off the decoder's load enables so that the real instruction register is loaded from the shadow word. The serial clock, the data input and the CPU clock are all asynchronous to the block. Each is synchronized into the fast system clock before edge detection. Consecutive edges on any of them must therefore be at least four system-clock cycles apart.

Top module: `dbg_shadow_scan`

## Requirements
- R1: The path is 64 bits long. From the data-out end, its byte order is: control, R0, R1, R2, R3, PC, IR high, IR low. Bits leave most significant first, and the data input enters at bit 0 of the IR low byte. Scanning a 64-bit word in and then scanning 64 more bits moves that same word out, with its bit 63 first.
- R2: `dec_takeover_o` equals bit 1 of the control byte.
- R3: `ir_overwrite_o` equals bit 2 of the control byte.
- R4: A falling edge of `cpu_clk_i` arms a capture. A rising edge of `cpu_clk_i` does not arm one.
- R5: While a capture is armed, the next rising serial-clock edge loads R0 to R3, PC and IR from the CPU inputs into their shadow bytes. On that edge the control byte is left unchanged and no shift takes place.
- R6: The capture enable clears on the first falling serial-clock edge after the load. Later rising edges shift again and do not reload, even if the CPU inputs change.
- R7: The path shifts on each rising serial-clock edge when no capture is armed. `miso_o` presents the current bit 63 before the next rising edge.
- R8: `shadow_ir_o` equals the two IR bytes of the path, with the IR high byte in bits 15:8.
- R9: An active-low reset clears every shadow byte and any armed capture. All outputs read 0 after reset.
- R10: Without an armed capture, serial-clock edges only shift. The previously scanned contents come back out, not the CPU values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all asynchronous inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| mosi_i | input | 1 | Serial data from the host |
| cpu_clk_i | input | 1 | CPU clock; a falling edge arms a capture |
| cpu_r0_i | input | 8 | Live CPU register R0 |
| cpu_r1_i | input | 8 | Live CPU register R1 |
| cpu_r2_i | input | 8 | Live CPU register R2 |
| cpu_r3_i | input | 8 | Live CPU register R3 |
| cpu_pc_i | input | 8 | Live CPU program counter |
| cpu_ir_i | input | 16 | Live CPU instruction register |
| miso_o | output | 1 | Serial data to the host (bit 63 of the path) |
| shadow_ir_o | output | 16 | Shadow instruction word for the decoder |
| dec_takeover_o | output | 1 | Decoder uses the shadow instruction word |
| ir_overwrite_o | output | 1 | Decoder load enables gated; IR loaded from the shadow word |

## Verification
The hardest case to reach is the capture handshake's timing. A CPU-clock edge must land between serial-clock pulses, and the CPU inputs must change after the load edge but before the scan-out. Only then does a reload on a later edge show up at the ports. The bench pulses the CPU clock on its own and issues one lone serial pulse to take the snapshot. It then changes every CPU input and scans out, so a stale enable would return the new values. A separate scenario holds the CPU clock high across a serial pulse. It then checks that the pulse shifted the path by one bit rather than loading it, which shows that only the falling CPU edge arms a capture.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int unsigned CTRL_TAKEOVER_BIT = 1;
  localparam int unsigned CTRL_IRWR_BIT     = 2;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_ARMED = 2'd1,
    LD_DONE  = 2'd2
  } ld_state_e;
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[STAGES-2:0], async_i};
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdc_edge.sv
module sdc_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= level_i;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    assign rise_o[i] = level_i[i] & ~prev_q[i];
    assign fall_o[i] = ~level_i[i] & prev_q[i];
  end
endmodule

// File: rtl/sdc_load_ctl.sv
module sdc_load_ctl
  import sdc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_fall_i,
  input  logic sclk_rise_i,
  input  logic sclk_fall_i,
  output logic load_o,
  output logic shift_o
);
  ld_state_e state_q, state_d;

  assign load_o  = (state_q == LD_ARMED) && sclk_rise_i;
  assign shift_o = sclk_rise_i && !load_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LD_ARMED: if (load_o)      state_d = LD_DONE;
      LD_DONE:  if (sclk_fall_i) state_d = LD_IDLE;
      default:  state_d = LD_IDLE;
    endcase
    if (cpu_fall_i) state_d = LD_ARMED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LD_IDLE;
    else         state_q <= state_d;
  end

  p_arm_on_cpu_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_fall_i |=> state_q == LD_ARMED);

  p_enable_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LD_DONE && sclk_fall_i && !cpu_fall_i) |=> state_q == LD_IDLE);

  p_single_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
endmodule

// File: rtl/sdc_chain.sv
module sdc_chain #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_LANES = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  shift_i,
  input  logic                                  load_i,
  input  logic                                  ser_i,
  input  logic [NUM_LANES-2:0][BYTE_W-1:0]      par_i,
  output logic [NUM_LANES-1:0][BYTE_W-1:0]      lanes_o
);
  localparam int unsigned CTRL_LANE = NUM_LANES - 1;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [BYTE_W-1:0] q;
    logic              shin;

    if (k == 0) begin : g_head
      assign shin = ser_i;
    end else begin : g_link
      assign shin = lanes_o[k-1][BYTE_W-1];
    end

    if (k == CTRL_LANE) begin : g_ctrl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (shift_i) q <= {q[BYTE_W-2:0], shin};
      end
    end else begin : g_data
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      q <= '0;
        else if (load_i)  q <= par_i[k];
        else if (shift_i) q <= {q[BYTE_W-2:0], shin};
      end
    end

    assign lanes_o[k] = q;
  end

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> lanes_o[CTRL_LANE-1:0] == $past(par_i));

  p_ctrl_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> $stable(lanes_o[CTRL_LANE]));

  p_serial_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> lanes_o[0][0] == $past(ser_i));

  p_out_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> lanes_o[CTRL_LANE][BYTE_W-1] == $past(lanes_o[CTRL_LANE][BYTE_W-2]));
endmodule

// File: rtl/dbg_shadow_scan.sv
module dbg_shadow_scan
  import sdc_pkg::*;
#(
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                mosi_i,
  input  logic                cpu_clk_i,
  input  logic [BYTE_W-1:0]   cpu_r0_i,
  input  logic [BYTE_W-1:0]   cpu_r1_i,
  input  logic [BYTE_W-1:0]   cpu_r2_i,
  input  logic [BYTE_W-1:0]   cpu_r3_i,
  input  logic [BYTE_W-1:0]   cpu_pc_i,
  input  logic [2*BYTE_W-1:0] cpu_ir_i,
  output logic                miso_o,
  output logic [2*BYTE_W-1:0] shadow_ir_o,
  output logic                dec_takeover_o,
  output logic                ir_overwrite_o
);
  localparam int unsigned NUM_LANES = 8;
  localparam int unsigned CTRL_LANE = NUM_LANES - 1;

  logic [2:0] sync_lv;
  logic [1:0] rise, fall;
  logic       load, shift;
  logic [NUM_LANES-2:0][BYTE_W-1:0] par;
  logic [NUM_LANES-1:0][BYTE_W-1:0] lanes;

  // bit 0: sclk, bit 1: cpu clock, bit 2: mosi (same latency as sclk)
  sdc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({mosi_i, cpu_clk_i, sclk_i}),
    .sync_o  (sync_lv)
  );

  sdc_edge #(.WIDTH(2)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (sync_lv[1:0]),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  sdc_load_ctl u_ldctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_fall_i  (fall[1]),
    .sclk_rise_i (rise[0]),
    .sclk_fall_i (fall[0]),
    .load_o      (load),
    .shift_o     (shift)
  );

  assign par[6] = cpu_r0_i;
  assign par[5] = cpu_r1_i;
  assign par[4] = cpu_r2_i;
  assign par[3] = cpu_r3_i;
  assign par[2] = cpu_pc_i;
  assign par[1] = cpu_ir_i[2*BYTE_W-1:BYTE_W];
  assign par[0] = cpu_ir_i[BYTE_W-1:0];

  sdc_chain #(.BYTE_W(BYTE_W), .NUM_LANES(NUM_LANES)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .load_i  (load),
    .ser_i   (sync_lv[2]),
    .par_i   (par),
    .lanes_o (lanes)
  );

  assign miso_o         = lanes[CTRL_LANE][BYTE_W-1];
  assign shadow_ir_o    = {lanes[1], lanes[0]};
  assign dec_takeover_o = lanes[CTRL_LANE][CTRL_TAKEOVER_BIT];
  assign ir_overwrite_o = lanes[CTRL_LANE][CTRL_IRWR_BIT];

  p_no_load_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load && shift));
endmodule

// File: tb/dbg_shadow_scan_bench.sv
module dbg_shadow_scan_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 8;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, mosi = 1'b0, cpu_clk = 1'b0;
  logic [7:0]  r0 = '0, r1 = '0, r2 = '0, r3 = '0, pc = '0;
  logic [15:0] ir = '0;
  logic        miso, takeover, irwr;
  logic [15:0] sh_ir;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_shadow_scan u_dbg_shadow_scan (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .mosi_i(mosi), .cpu_clk_i(cpu_clk),
    .cpu_r0_i(r0), .cpu_r1_i(r1), .cpu_r2_i(r2), .cpu_r3_i(r3), .cpu_pc_i(pc),
    .cpu_ir_i(ir), .miso_o(miso), .shadow_ir_o(sh_ir),
    .dec_takeover_o(takeover), .ir_overwrite_o(irwr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_pulse(input logic bit_v);
    mosi = bit_v;
    idle(HALF_BIT);
    sclk = 1'b1;
    idle(HALF_BIT);
    sclk = 1'b0;
    idle(HALF_BIT);
  endtask

  task automatic cpu_pulse();
    cpu_clk = 1'b1;
    idle(HALF_BIT);
    cpu_clk = 1'b0;
    idle(HALF_BIT);
  endtask

  task automatic scan(input logic [63:0] tx, output logic [63:0] rx);
    for (int i = 63; i >= 0; i--) begin
      mosi = tx[i];
      idle(HALF_BIT);
      rx[i] = miso;
      sclk = 1'b1;
      idle(HALF_BIT);
      sclk = 1'b0;
    end
    idle(HALF_BIT);
  endtask

  task automatic t_reset();
    chk("R9 miso after reset", {63'd0, miso}, 64'd0);
    chk("R9 controls after reset", {62'd0, takeover, irwr}, 64'd0);
    chk("R9 shadow IR after reset", {48'd0, sh_ir}, 64'd0);
  endtask

  task automatic t_shift();
    logic [63:0] a = 64'h02_11_22_33_44_55_A6C3;
    logic [63:0] b = 64'h06_F0_0F_5A_A5_81_7E18;
    logic [63:0] rx;
    scan(a, rx);
    chk("R9 chain empty after reset", rx, 64'd0);
    chk("R2 takeover set by ctrl bit 1", {63'd0, takeover}, 64'd1);
    chk("R3 overwrite clear", {63'd0, irwr}, 64'd0);
    chk("R8 shadow IR", {48'd0, sh_ir}, {48'd0, a[15:0]});
    scan(b, rx);
    chk("R1 R10 scanned word returns intact", rx, a);
    chk("R3 overwrite set by ctrl bit 2", {62'd0, takeover, irwr}, 64'd3);
    chk("R8 shadow IR second", {48'd0, sh_ir}, {48'd0, b[15:0]});
  endtask

  task automatic t_capture();
    logic [63:0] rx;
    r0 = 8'h12; r1 = 8'h34; r2 = 8'h56; r3 = 8'h78; pc = 8'h9A; ir = 16'hBCDE;
    cpu_pulse();
    spi_pulse(1'b1);
    r0 = 8'hFF; r1 = 8'hEE; r2 = 8'hDD; r3 = 8'hCC; pc = 8'hBB; ir = 16'hAA99;
    scan(64'h00_00_00_00_00_00_0000, rx);
    chk("R5 R6 capture of CPU regs, ctrl kept", rx, 64'h06_12_34_56_78_9A_BCDE);
    chk("R2 R3 controls cleared", {62'd0, takeover, irwr}, 64'd0);
  endtask

  task automatic t_rise_no_arm();
    logic [63:0] d = 64'h02_C3_3C_96_69_0F_F00F;
    logic [63:0] rx;
    scan(d, rx);
    cpu_clk = 1'b1;
    idle(HALF_BIT);
    spi_pulse(1'b1);
    scan(64'd0, rx);
    chk("R4 R7 rising CPU edge does not arm, pulse shifts", rx, {d[62:0], 1'b1});
    cpu_clk = 1'b0;
    idle(HALF_BIT);
  endtask

  task automatic t_reset_mid();
    logic [63:0] rx;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    scan(64'h04_00_00_00_00_00_0001, rx);
    chk("R9 reset cleared chain and armed capture", rx, 64'd0);
    chk("R3 overwrite alone", {62'd0, takeover, irwr}, 64'd1);
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_shift();
    t_capture();
    t_rise_no_arm();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule